// File: doc/BRIEF.md
# Mixed-sign byte dot-product accumulator

This block is a pipelined SIMD datapath for 8-bit integer inference kernels. Each 32-bit lane of the operands holds four bytes. Bytes of the unsigned operand are read as values 0 to 255. The matching bytes of the signed operand are read as values -128 to 127. The four products in a lane are added together, and the sum is added to the 32-bit value in the same lane of the accumulator input. The lane result wraps modulo 2^32.

A two-bit mode input selects the operation:
- **Width:** the full 128-bit form computes four lanes. The half 64-bit form computes only the two low lanes and passes the upper 64 bits of the accumulator through unchanged.
- **Broadcast:** the by-element form takes one 32-bit group from the low 64 bits of the signed operand and uses it in every lane. A one-bit index picks the group.

A result appears two clocks after its operands are presented. A new operation may start every cycle. The block has no flag or status outputs.

Top module: `usdot_acc`

## Requirements
- R1: Result lane i (bits 32i+31 to 32i) is formed from bytes 4i to 4i+3 of `src_u` paired position by position with the same byte positions of `src_s`, where byte k is bits 8k+7 to 8k.
- R2: Each byte of `src_u` is zero-extended before it is multiplied, so 8'hFF counts as 255.
- R3: Each byte of `src_s` is sign-extended before it is multiplied, so 8'h80 counts as -128 and 8'hFF as -1.
- R4: The four byte products of an active lane are summed, and the sum is added to that lane of `acc_in`. The result replaces the lane in `acc_out`. When `src_u` is all zero, `acc_out` equals `acc_in`.
- R5: The accumulate wraps modulo 2^32 with no saturation. For example, 32'h7FFFFFFF plus a dot product of 4 gives 32'h80000003.
- R6: `in_mode[0]` = 1 selects the full form, in which all four lanes are computed.
- R7: `in_mode[0]` = 0 selects the half form. Only lanes 0 and 1 are computed, and `acc_out[127:64]` equals `acc_in[127:64]`.
- R8: `in_mode[1]` = 1 selects the broadcast form. Every active lane uses the four signed bytes at `src_s[32*in_idx +: 32]`, and `src_s[127:64]` has no effect on the result.
- R9: `out_valid` is high exactly two clocks after the cycle in which `in_valid` was high. Operations presented on consecutive cycles give results on consecutive cycles, in order.
- R10: While `rst_n` is low, and in the first cycle after it is released, `out_valid` is low. An operation in flight when reset is asserted produces no result.
- R11: `acc_out` holds its value in every cycle in which `out_valid` is low. Inputs presented with `in_valid` low have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operands present this cycle |
| in_mode | input | 2 | Bit 0: full (1) or half (0) width. Bit 1: broadcast form |
| in_idx | input | 1 | Broadcast group select within `src_s[63:0]` |
| src_u | input | 128 | Unsigned byte operand |
| src_s | input | 128 | Signed byte operand |
| acc_in | input | 128 | Accumulator lanes, four 32-bit two's complement values |
| out_valid | output | 1 | `acc_out` carries a new result |
| acc_out | output | 128 | Updated accumulator lanes |

## Verification
The bench targets the value extremes. It applies 8'hFF unsigned against 8'h80 signed to give the most negative lane sum, -130560, and a design that sign-extended the unsigned byte or zero-extended the signed byte would give a different value. It also applies an accumulator of 32'h7FFFFFFF; a design that saturated would not reach 32'h80000003, and a design that lost the sign of the 19-bit sum would corrupt the negative cases.

In the half form the bench checks that the upper 64 bits pass through untouched. In the broadcast form it uses both index values while placing decoy bytes in the rest of `src_s`, which exposes a design that reads per-lane groups or the wrong group. Back-to-back streams and a reset asserted while an operation is in flight expose pipeline registers that drop, repeat or leak results.

// File: rtl/usdot_pkg.sv
package usdot_pkg;

  // Bit 0 of the mode: full width (1) or half width (0).
  // Bit 1 of the mode: broadcast one signed group to every lane.
  typedef enum logic [1:0] {
    MODE_HALF      = 2'b00,
    MODE_FULL      = 2'b01,
    MODE_HALF_BCST = 2'b10,
    MODE_FULL_BCST = 2'b11
  } usdot_mode_e;

  function automatic logic mode_full(input logic [1:0] m);
    return m[0];
  endfunction

  function automatic logic mode_bcst(input logic [1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/usdot_opsel.sv
// Chooses the signed byte group each lane sees: its own group, or one
// group from the low part of the signed source, broadcast to every lane.
module usdot_opsel #(
  parameter int LANES     = 4,
  parameter int GRP_W     = 32,
  parameter int BCST_GRPS = 2,
  localparam int VEC_W    = LANES * GRP_W,
  localparam int IDX_W    = (BCST_GRPS > 1) ? $clog2(BCST_GRPS) : 1
) (
  input  logic [VEC_W-1:0] src_s,
  input  logic             bcst,
  input  logic [IDX_W-1:0] idx,
  output logic [VEC_W-1:0] s_eff
);

  logic [GRP_W-1:0] bcst_grp;

  always_comb begin
    bcst_grp = '0;
    for (int g = 0; g < BCST_GRPS; g++) begin
      if (idx == IDX_W'(g)) bcst_grp = src_s[g*GRP_W +: GRP_W];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign s_eff[l*GRP_W +: GRP_W] = bcst ? bcst_grp : src_s[l*GRP_W +: GRP_W];
  end

endmodule

// File: rtl/usdot_lane.sv
// One lane's products and their sum: unsigned bytes times signed bytes.
module usdot_lane #(
  parameter int BYTES   = 4,
  parameter int BYTE_W  = 8,
  localparam int GRP_W  = BYTES * BYTE_W,
  localparam int PROD_W = 2 * BYTE_W + 1,
  localparam int SUM_W  = PROD_W + $clog2(BYTES)
) (
  input  logic [GRP_W-1:0]        u_grp,
  input  logic [GRP_W-1:0]        s_grp,
  output logic signed [SUM_W-1:0] dot
);

  logic signed [PROD_W-1:0] prod [BYTES];

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] ub;
    logic [BYTE_W-1:0] sb;
    assign ub = u_grp[b*BYTE_W +: BYTE_W];
    assign sb = s_grp[b*BYTE_W +: BYTE_W];
    assign prod[b] = $signed({{(PROD_W-BYTE_W){1'b0}}, ub})
                   * $signed({{(PROD_W-BYTE_W){sb[BYTE_W-1]}}, sb});
  end

  always_comb begin
    dot = '0;
    for (int b = 0; b < BYTES; b++) begin
      dot = dot + SUM_W'(prod[b]);
    end
  end

endmodule

// File: rtl/usdot_acc.sv
// Two-stage mixed-sign dot-product accumulator.
// Stage 1 registers the per-lane dot sums; stage 2 registers the accumulate.
module usdot_acc #(
  parameter int LANES     = 4,
  parameter int BYTES     = 4,
  parameter int BYTE_W    = 8,
  parameter int BCST_GRPS = 2,
  localparam int GRP_W    = BYTES * BYTE_W,
  localparam int VEC_W    = LANES * GRP_W,
  localparam int HALF_L   = LANES / 2,
  localparam int SUM_W    = 2 * BYTE_W + 1 + $clog2(BYTES),
  localparam int IDX_W    = (BCST_GRPS > 1) ? $clog2(BCST_GRPS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_mode,
  input  logic [IDX_W-1:0] in_idx,
  input  logic [VEC_W-1:0] src_u,
  input  logic [VEC_W-1:0] src_s,
  input  logic [VEC_W-1:0] acc_in,
  output logic             out_valid,
  output logic [VEC_W-1:0] acc_out
);
  import usdot_pkg::*;

  // ---------------- stage 1: operand select and lane dot sums ------------
  logic [VEC_W-1:0]        s_eff;
  logic signed [SUM_W-1:0] dot_d [LANES];
  logic [LANES-1:0]        lane_en_d;

  usdot_opsel #(
    .LANES(LANES), .GRP_W(GRP_W), .BCST_GRPS(BCST_GRPS)
  ) u_opsel (
    .src_s (src_s),
    .bcst  (mode_bcst(in_mode)),
    .idx   (in_idx),
    .s_eff (s_eff)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    usdot_lane #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_lane (
      .u_grp (src_u[l*GRP_W +: GRP_W]),
      .s_grp (s_eff[l*GRP_W +: GRP_W]),
      .dot   (dot_d[l])
    );
    assign lane_en_d[l] = mode_full(in_mode) || (l < HALF_L);
  end

  logic                    s1_valid_q;
  logic signed [SUM_W-1:0] s1_dot_q [LANES];
  logic [LANES-1:0]        s1_en_q;
  logic [VEC_W-1:0]        s1_acc_q;
  logic                    s1_ce;

  assign s1_ce = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid_q <= 1'b0;
    else        s1_valid_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (s1_ce) begin
      for (int l = 0; l < LANES; l++) s1_dot_q[l] <= dot_d[l];
      s1_en_q  <= lane_en_d;
      s1_acc_q <= acc_in;
    end
  end

  // ---------------- stage 2: accumulate ----------------------------------
  logic [VEC_W-1:0] res_d;
  logic             out_ce;

  always_comb begin
    res_d = s1_acc_q;
    for (int l = 0; l < LANES; l++) begin
      if (s1_en_q[l]) begin
        res_d[l*GRP_W +: GRP_W] = s1_acc_q[l*GRP_W +: GRP_W]
          + {{(GRP_W-SUM_W){s1_dot_q[l][SUM_W-1]}}, s1_dot_q[l]};
      end
    end
  end

  assign out_ce = s1_valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s1_valid_q;
  end

  always_ff @(posedge clk) begin
    if (out_ce) acc_out <= res_d;
  end

endmodule

// File: rtl/usdot_acc_chk.sv
module usdot_acc_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       in_mode,
  input logic [VEC_W-1:0] src_u,
  input logic [VEC_W-1:0] acc_in,
  input logic             out_valid,
  input logic [VEC_W-1:0] acc_out
);
  localparam int HW = VEC_W / 2;

  logic [1:0] age;   // edges since reset release, saturating
  logic       seen;  // a result has been produced

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age  <= 2'd0;
      seen <= 1'b0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      if (out_valid)   seen <= 1'b1;
    end
  end

  // R9: fixed two-cycle latency
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R7: half form leaves the upper half unchanged
  p_upper_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && out_valid && !$past(in_mode[0], 2))
      |-> (acc_out[VEC_W-1:HW] == $past(acc_in[VEC_W-1:HW], 2)));

  // R4: zero unsigned operand adds nothing
  p_zero_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && out_valid && $past(src_u == '0, 2))
      |-> (acc_out == $past(acc_in, 2)));

  // R11: output holds while no result is flagged
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !out_valid) |-> $stable(acc_out));

  // R10: reset clears the output strobe
  p_reset_clear_r10: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

endmodule

bind usdot_acc usdot_acc_chk #(.VEC_W(128)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_mode   (in_mode),
  .src_u     (src_u),
  .acc_in    (acc_in),
  .out_valid (out_valid),
  .acc_out   (acc_out)
);

// File: tb/usdot_acc_bench.sv
`timescale 1ns/1ps
module usdot_acc_bench;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   in_mode;
  logic [0:0]   in_idx;
  logic [127:0] src_u;
  logic [127:0] src_s;
  logic [127:0] acc_in;
  logic         out_valid;
  logic [127:0] acc_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  usdot_acc u_usdot_acc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_idx(in_idx), .src_u(src_u), .src_s(src_s), .acc_in(acc_in),
    .out_valid(out_valid), .acc_out(acc_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference from the requirements.
  function automatic logic [127:0] model(input logic [1:0] m, input logic ix,
      input logic [127:0] u, input logic [127:0] s, input logic [127:0] a);
    logic [127:0] r;
    r = a;
    for (int l = 0; l < 4; l++) begin
      if (m[0] || l < 2) begin
        int acc;
        acc = int'(a[l*32 +: 32]);
        for (int b = 0; b < 4; b++) begin
          logic [7:0] ub;
          logic signed [7:0] sb;
          ub = u[(l*4+b)*8 +: 8];
          sb = m[1] ? s[(32*int'(ix)) + b*8 +: 8] : s[(l*4+b)*8 +: 8];
          acc = acc + int'({24'b0, ub}) * int'(sb);
        end
        r[l*32 +: 32] = acc;
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] got,
                       input logic [127:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    in_valid = 1'b0;
    in_mode  = 2'b01;
    in_idx   = 1'b0;
    src_u    = '0;
    src_s    = '0;
    acc_in   = '0;
  endtask

  // Issue one operation and return its result two clocks later.
  task automatic run_op(input logic [1:0] m, input logic ix, input logic [127:0] u,
      input logic [127:0] s, input logic [127:0] a, input string req,
      output logic [127:0] res);
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_idx = ix; src_u = u; src_s = s; acc_in = a;
    @(negedge clk);
    idle_inputs();
    check({req, " R9 no early valid"}, 128'(out_valid), 128'(1'b0));
    @(negedge clk);
    check({req, " R9 valid at 2"}, 128'(out_valid), 128'(1'b1));
    res = acc_out;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    check("R10 valid low in reset", 128'(out_valid), 128'(1'b0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 valid low after release", 128'(out_valid), 128'(1'b0));
  endtask

  task automatic t_lane_pairing();
    logic [127:0] u, s, a, r;
    u = 128'h04030201_08070605_0C0B0A09_100F0E0D;
    s = 128'h01020304_FF01FF01_00000001_7F808081;
    a = 128'h00000010_00000020_FFFFFFF0_00001000;
    run_op(2'b01, 1'b0, u, s, a, "R1", r);
    check("R1 R4 R6 byte pairing", r, model(2'b01, 1'b0, u, s, a));
    // lane 3: 4*1+3*2+2*3+1*4 = 20, plus 16 = 36
    check("R1 lane3 value", 128'(r[127:96]), 128'(32'd36));
  endtask

  task automatic t_extremes();
    logic [127:0] r;
    run_op(2'b01, 1'b0, {16{8'hFF}}, {16{8'h80}}, '0, "R2 R3", r);
    check("R2 R3 most negative", r, {4{32'hFFFE0200}});
    run_op(2'b01, 1'b0, {16{8'hFF}}, {16{8'h7F}}, '0, "R2", r);
    check("R2 most positive", r, {4{32'h0001FA04}});
    run_op(2'b01, 1'b0, {16{8'h01}}, {16{8'hFF}}, {4{32'd10}}, "R3", r);
    check("R3 minus one bytes", r, {4{32'd6}});
  endtask

  task automatic t_wrap();
    logic [127:0] r;
    run_op(2'b01, 1'b0, {16{8'h01}}, {16{8'h01}}, {4{32'h7FFFFFFF}}, "R5", r);
    check("R5 wrap positive", r, {4{32'h80000003}});
    run_op(2'b01, 1'b0, {16{8'h01}}, {16{8'hFF}}, {4{32'h80000000}}, "R5", r);
    check("R5 wrap negative", r, {4{32'h7FFFFFFC}});
  endtask

  task automatic t_half();
    logic [127:0] u, s, a, r;
    u = {16{8'h37}};
    s = {8{8'h91, 8'h05}};
    a = 128'hDEADBEEF_CAFEF00D_00000100_FFFFFF00;
    run_op(2'b00, 1'b0, u, s, a, "R7", r);
    check("R7 half form", r, model(2'b00, 1'b0, u, s, a));
    check("R7 upper unchanged", 128'(r[127:64]), 128'(a[127:64]));
  endtask

  task automatic t_bcst();
    logic [127:0] u, s, a, r;
    u = 128'h01010101_02020202_03030303_04040404;
    s = 128'h55AA55AA_66778899_FE030201_04FF7F80;
    a = {4{32'd1000}};
    run_op(2'b11, 1'b0, u, s, a, "R8", r);
    check("R8 bcst group 0", r, model(2'b11, 1'b0, u, s, a));
    run_op(2'b11, 1'b1, u, s, a, "R8", r);
    check("R8 bcst group 1", r, model(2'b11, 1'b1, u, s, a));
    // lane 3 with group 1: 1*(1+2+3-2) = 4
    check("R8 lane3 group1 value", 128'(r[127:96]), 128'(32'd1004));
    run_op(2'b11, 1'b1, u, {64'h0123456789ABCDEF, s[63:0]}, a, "R8", r);
    check("R8 upper signed ignored", r, model(2'b11, 1'b1, u, s, a));
    run_op(2'b10, 1'b1, u, s, a, "R8 R7", r);
    check("R8 R7 half bcst", r, model(2'b10, 1'b1, u, s, a));
  endtask

  task automatic t_stream();
    logic [127:0] eu [5];
    logic [127:0] es [5];
    logic [127:0] ea [5];
    logic [1:0]   em [5];
    for (int k = 0; k < 5; k++) begin
      eu[k] = {$urandom, $urandom, $urandom, $urandom};
      es[k] = {$urandom, $urandom, $urandom, $urandom};
      ea[k] = {$urandom, $urandom, $urandom, $urandom};
      em[k] = 2'(k);
    end
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        check("R9 stream valid", 128'(out_valid), 128'(1'b1));
        check("R9 stream data", acc_out,
              model(em[k-2], 1'(k-2), eu[k-2], es[k-2], ea[k-2]));
      end
      if (k < 5) begin
        in_valid = 1'b1; in_mode = em[k]; in_idx = 1'(k);
        src_u = eu[k]; src_s = es[k]; acc_in = ea[k];
      end else begin
        idle_inputs();
      end
    end
    @(negedge clk);
    check("R9 stream ends", 128'(out_valid), 128'(1'b0));
  endtask

  task automatic t_hold();
    logic [127:0] r;
    run_op(2'b01, 1'b0, {16{8'h11}}, {16{8'h22}}, {4{32'd5}}, "R11", r);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b0; in_mode = 2'(k); src_u = '1; src_s = '1; acc_in = '1;
    end
    @(negedge clk);
    @(negedge clk);
    check("R11 hold valid low", 128'(out_valid), 128'(1'b0));
    check("R11 hold data", acc_out, r);
    idle_inputs();
  endtask

  task automatic t_reset_flight();
    @(negedge clk);
    in_valid = 1'b1; src_u = {16{8'h02}}; src_s = {16{8'h03}};
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 flight dropped", 128'(out_valid), 128'(1'b0));
    @(negedge clk);
    check("R10 flight dropped later", 128'(out_valid), 128'(1'b0));
  endtask

  task automatic t_mixed();
    logic [127:0] u, s, a, r;
    for (int k = 0; k < 6; k++) begin
      u = {$urandom, $urandom, $urandom, $urandom};
      s = {$urandom, $urandom, $urandom, $urandom};
      a = {$urandom, $urandom, $urandom, $urandom};
      run_op(2'(k), 1'(k >> 1), u, s, a, "R4", r);
      check("R4 R6 mixed pattern", r, model(2'(k), 1'(k >> 1), u, s, a));
    end
  endtask

  initial begin
    t_reset();
    t_lane_pairing();
    t_extremes();
    t_wrap();
    t_half();
    t_bcst();
    t_stream();
    t_hold();
    t_reset_flight();
    t_mixed();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL R9 watchdog got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule